// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple host port and a single-data-rate SDRAM with four banks, a 13-bit row address and a 10-bit column address. After reset it brings the device up: it precharges every bank, runs two auto-refresh cycles and programs the mode word for single-beat bursts at CAS latency 3. It then serves one host request at a time. Each access activates a row, issues one read or write with auto-precharge, and then waits until the bank is free again. A refresh timer raises a request about every 7.8 us. A pending refresh is served before any waiting host request.

All command spacing comes from parameters counted in clock cycles. The defaults fit a 7.5 ns clock: 3 cycles for activate to column command, 3 for precharge, 6 for the active time, 9 for the row cycle and 2 for write recovery. Because every access closes its own row, consecutive activates are always at least T_GAP = max(tRC, tRCD+tWR+tRP, tRAS+tRP, tRRD) cycles apart. With the defaults T_GAP is 9. Read data is returned on a one-cycle valid strobe. The data bus is split into a driven output, an output enable and a sampled input.

Top module: `sdr_cmd_seq`

## Requirements
- R1: While reset is held, sd_cke is low and the command lines show no-operation. req_ready, rd_valid and sd_dq_oe are all low.
- R2: After reset the controller issues a set of start-up commands in a fixed order. First comes a precharge with A10 high. tRP cycles later comes the first auto-refresh. tRC cycles after that comes a second auto-refresh. tRC cycles after that comes the mode register set, with A = 0x030 (bits 2:0 = 000 for one beat, bit 3 = 0 for sequential order, bits 6:4 = 011 for latency 3) and BA = 00. No host command follows until at least 2 cycles after the mode register set.
- R3: Commands are encoded on {CS#,RAS#,CAS#,WE#} as follows: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-operation 0111. A write request produces a write command and a read request produces a read command.
- R4: req_addr[24:23] selects the bank, req_addr[22:10] the row and req_addr[9:0] the column. The activate for an accepted request (req_valid and req_ready high at a clock edge) appears in the cycle right after that edge, with BA = bank and A = row.
- R5: The read or write command comes exactly tRCD cycles after its activate. It carries the same BA, A10 = 1 (auto-precharge), A[9:0] = column and A[12:11] = 0.
- R6: sd_dq_oe is high only in the cycle of a write command. In that cycle sd_dq_out carries the write data and sd_dqm carries req_mask (bit 1 is the upper byte; a 1 blocks that byte). In every other cycle sd_dqm is 0.
- R7: The DQ input is sampled CAS-latency cycles after the read command reaches the device. rd_valid pulses for one cycle, CL+1 cycles after the read command's cycle, and rd_data then holds the word last written to that address.
- R8: Two activates are never closer than T_GAP cycles. req_ready is high only while the controller is idle and the output command is no-operation.
- R9: Once the mode word is set, a refresh request is raised every REF_INTERVAL cycles. An auto-refresh is issued only when at least T_GAP cycles have passed since the last activate. The next command follows at least tRC cycles after the refresh.
- R10: A pending refresh is served before a waiting host request, so that request's activate comes exactly tRC cycles after the refresh. Even under continuous traffic, consecutive refreshes stay within REF_INTERVAL ± (T_GAP+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask for writes, 1 = keep old byte |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed address |
| sd_dqm | output | 2 | Data mask |
| sd_dq_out | output | 16 | Data driven to the device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data sampled from the device |

## Verification
The assertions assume the host keeps req_valid and its fields steady only as far as the handshake needs. They also assume sd_dq_in carries read data exactly CL cycles after a read reaches the device. The bench supplies this with a memory model that latches commands at the clock edge and drives its data from a two-stage delay line. That model also fills non-read cycles with a marker value, so a sample taken in the wrong cycle shows up. Host requests are driven only on falling edges and only change after a handshake. Addresses come from a small pool, so random reads return known data and masked writes merge with known old bytes.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

    // {CS#, RAS#, CAS#, WE#}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_PRE_ALL,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_MRS,
        ST_IDLE,
        ST_RW,
        ST_WAIT
    } seq_st_e;

    // one-beat burst, sequential order, latency in bits 6:4
    function automatic logic [12:0] mode_word(input logic [2:0] lat);
        return {6'b000000, lat, 4'b0000};
    endfunction

    function automatic int max2(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
    parameter int INTERVAL = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (ack) d.pend = 1'b0;
        if (!en) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(INTERVAL - 1)) begin
            d.cnt  = '0;
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.pend;
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CL     = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic [CL-1:0]     pipe;
        logic              vld;
        logic [DATA_W-1:0] word;
    } cap_t;

    cap_t q, d;
    logic last;

    generate
        if (CL == 1) begin : g_one
            always_comb begin
                d = q;
                d.pipe = issue;
                last   = q.pipe[0];
                d.vld  = last;
                if (last) d.word = dq_in;
            end
        end else begin : g_multi
            always_comb begin
                d = q;
                d.pipe = {q.pipe[CL-2:0], issue};
                last   = q.pipe[CL-1];
                d.vld  = last;
                if (last) d.word = dq_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.vld;
    assign data  = q.word;
endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
    import sdr_cmd_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 16,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RAS        = 6,
    parameter int T_RC         = 9,
    parameter int T_RRD        = 2,
    parameter int T_WR         = 2,
    parameter int T_MRD        = 2,
    parameter int CAS_LAT      = 3,
    parameter int REF_INTERVAL = 1040
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    input  logic [DATA_W/8-1:0]               req_mask,
    output logic                              rd_valid,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              sd_cke,
    output logic                              sd_cs_n,
    output logic                              sd_ras_n,
    output logic                              sd_cas_n,
    output logic                              sd_we_n,
    output logic [BANK_W-1:0]                 sd_ba,
    output logic [ROW_W-1:0]                  sd_a,
    output logic [DATA_W/8-1:0]               sd_dqm,
    output logic [DATA_W-1:0]                 sd_dq_out,
    output logic                              sd_dq_oe,
    input  logic [DATA_W-1:0]                 sd_dq_in
);
    localparam int MASK_W = DATA_W / 8;
    localparam int A_W    = ROW_W;
    localparam int AP_BIT = 10;
    localparam int T_GAP  = max2(max2(T_RC, T_RCD + T_WR + T_RP),
                                 max2(T_RAS + T_RP, T_RRD));
    localparam int CNT_W  = $clog2(max2(T_GAP, T_RC) + 2);

    typedef struct packed {
        seq_st_e           st;
        seq_st_e           nxt;
        logic [CNT_W-1:0]  cnt;
        sdr_cmd_e          cmd;
        logic              cke;
        logic              live;
        logic [BANK_W-1:0] ba;
        logic [A_W-1:0]    a;
        logic [MASK_W-1:0] dqm;
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [MASK_W-1:0] mask;
    } seq_t;

    seq_t q, d;
    logic ref_pending;
    logic ref_ack;

    sdr_ref_timer #(.INTERVAL(REF_INTERVAL)) ref_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (q.live),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    sdr_rd_capture #(.CL(CAS_LAT), .DATA_W(DATA_W)) rd_cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (q.cmd == CMD_RD),
        .dq_in (sd_dq_in),
        .valid (rd_valid),
        .data  (rd_data)
    );

    assign req_ready = (q.st == ST_IDLE) && !ref_pending;

    always_comb begin
        d       = q;
        d.cmd   = CMD_NOP;
        d.cke   = 1'b1;
        d.ba    = '0;
        d.a     = '0;
        d.dqm   = '0;
        d.oe    = 1'b0;
        ref_ack = 1'b0;
        unique case (q.st)
            ST_BOOT: d.st = ST_PRE_ALL;
            ST_PRE_ALL: begin
                d.cmd       = CMD_PRE;
                d.a[AP_BIT] = 1'b1;
                d.st        = ST_WAIT;
                d.cnt       = CNT_W'(T_RP - 1);
                d.nxt       = ST_INIT_REF1;
            end
            ST_INIT_REF1, ST_INIT_REF2: begin
                d.cmd = CMD_REF;
                d.st  = ST_WAIT;
                d.cnt = CNT_W'(T_RC - 1);
                d.nxt = (q.st == ST_INIT_REF1) ? ST_INIT_REF2 : ST_MRS;
            end
            ST_MRS: begin
                d.cmd  = CMD_MRS;
                d.a    = A_W'(mode_word(3'(CAS_LAT)));
                d.live = 1'b1;
                d.st   = ST_WAIT;
                d.cnt  = CNT_W'(T_MRD - 1);
                d.nxt  = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_pending) begin
                    d.cmd   = CMD_REF;
                    ref_ack = 1'b1;
                    d.st    = ST_WAIT;
                    d.cnt   = CNT_W'(T_RC - 1);
                    d.nxt   = ST_IDLE;
                end else if (req_valid) begin
                    d.we    = req_write;
                    d.bank  = req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
                    d.row   = req_addr[ROW_W+COL_W-1 -: ROW_W];
                    d.col   = req_addr[COL_W-1:0];
                    d.wdata = req_wdata;
                    d.mask  = req_mask;
                    d.cmd   = CMD_ACT;
                    d.ba    = req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
                    d.a     = req_addr[ROW_W+COL_W-1 -: ROW_W];
                    d.st    = ST_WAIT;
                    d.cnt   = CNT_W'(T_RCD - 1);
                    d.nxt   = ST_RW;
                end
            end
            ST_RW: begin
                d.cmd              = q.we ? CMD_WR : CMD_RD;
                d.ba               = q.bank;
                d.a[COL_W-1:0]     = q.col;
                d.a[AP_BIT]        = 1'b1;
                if (q.we) begin
                    d.oe  = 1'b1;
                    d.dq  = q.wdata;
                    d.dqm = q.mask;
                end
                d.st  = ST_WAIT;
                d.cnt = CNT_W'(T_GAP - T_RCD - 1);
                d.nxt = ST_IDLE;
            end
            ST_WAIT: begin
                if (q.cnt <= CNT_W'(1)) d.st = q.nxt;
                else                    d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_BOOT;
            q.nxt <= ST_BOOT;
            q.cmd <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign sd_cke    = q.cke;
    assign sd_cs_n   = q.cmd[3];
    assign sd_ras_n  = q.cmd[2];
    assign sd_cas_n  = q.cmd[1];
    assign sd_we_n   = q.cmd[0];
    assign sd_ba     = q.ba;
    assign sd_a      = q.a;
    assign sd_dqm    = q.dqm;
    assign sd_dq_out = q.dq;
    assign sd_dq_oe  = q.oe;
endmodule

// File: rtl/sdr_cmd_seq_chk.sv
module sdr_cmd_seq_chk
    import sdr_cmd_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RAS   = 6,
    parameter int T_RC    = 9,
    parameter int T_RRD   = 2,
    parameter int T_WR    = 2,
    parameter int CAS_LAT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_cke,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_a,
    input logic             sd_dq_oe,
    input logic             rd_valid,
    input logic             req_ready
);
    localparam int T_GAP = max2(max2(T_RC, T_RCD + T_WR + T_RP),
                                max2(T_RAS + T_RP, T_RRD));
    localparam logic [7:0] SAT  = 8'd255;
    localparam logic [7:0] RCD8 = 8'(T_RCD);
    localparam logic [7:0] GAP8 = 8'(T_GAP);
    localparam logic [7:0] RC8  = 8'(T_RC);
    localparam logic [7:0] RDL8 = 8'(CAS_LAT + 1);

    logic [3:0] cmd;
    logic [7:0] since_act, since_ref, since_rd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SAT;
            since_ref <= SAT;
            since_rd  <= SAT;
        end else begin
            since_act <= (cmd == CMD_ACT) ? 8'd1 : ((since_act == SAT) ? SAT : since_act + 8'd1);
            since_ref <= (cmd == CMD_REF) ? 8'd1 : ((since_ref == SAT) ? SAT : since_ref + 8'd1);
            since_rd  <= (cmd == CMD_RD)  ? 8'd1 : ((since_rd  == SAT) ? SAT : since_rd  + 8'd1);
        end
    end

    // R5
    rcd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (since_act == RCD8 && sd_a[10]));

    // R8
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> (since_act >= GAP8 && since_ref >= RC8));

    // R9
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (since_act >= GAP8 && since_ref >= RC8));

    // R2
    mrs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |=> (cmd == CMD_NOP));

    // R6
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == CMD_WR));

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (since_rd == RDL8));

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd == CMD_NOP && sd_cke));
endmodule

bind sdr_cmd_seq sdr_cmd_seq_chk #(
    .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_RRD(T_RRD), .T_WR(T_WR), .CAS_LAT(CAS_LAT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_a      (sd_a),
    .sd_dq_oe  (sd_dq_oe),
    .rd_valid  (rd_valid),
    .req_ready (req_ready)
);

// File: tb/sdr_cmd_seq_tb.sv
module sdr_cmd_seq_tb_top;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                           C_NOP = 4'b0111;
    localparam int TRCD = 3, TRP = 3, TRC = 9, TGAP = 9, RDLAT = 4, RINT = 1040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [15:0] rd_data, sd_dq_out;
    logic [15:0] sd_dq_in = 16'hDEAD;
    logic [1:0]  sd_ba, sd_dqm;
    logic [12:0] sd_a;

    always #4 clk = ~clk;

    sdr_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: latches commands at the rising edge
    logic [15:0] mem_m [logic [24:0]];
    logic [12:0] open_row [4];
    bit          open_v [4];
    logic        p0v = 0, p1v = 0;
    logic [15:0] p0d = '0, p1d = '0;

    function automatic logic [15:0] rd_mem(input logic [24:0] k);
        return mem_m.exists(k) ? mem_m[k] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        logic [24:0] k;
        logic [15:0] o;
        k = {sd_ba, open_row[sd_ba], sd_a[9:0]};
        p0v <= 1'b0;
        if (rst_n && cmd == C_ACT) begin
            open_row[sd_ba] = sd_a;
            open_v[sd_ba]   = 1'b1;
        end
        if (rst_n && cmd == C_WR) begin
            o = rd_mem(k);
            mem_m[k] = sd_dq_oe ? {sd_dqm[1] ? o[15:8] : sd_dq_out[15:8],
                                   sd_dqm[0] ? o[7:0]  : sd_dq_out[7:0]} : 16'hBAD0;
            if (sd_a[10]) open_v[sd_ba] = 1'b0;
        end
        if (rst_n && cmd == C_RD) begin
            p0v <= 1'b1;
            p0d <= open_v[sd_ba] ? rd_mem(k) : 16'hBAD1;
            if (sd_a[10]) open_v[sd_ba] = 1'b0;
        end
        p1v <= p0v;
        p1d <= p0d;
        sd_dq_in <= p1v ? p1d : 16'hDEAD;
    end

    // host-side expectations
    logic [15:0] exp_mem [logic [24:0]];
    logic [15:0] expq [$];
    int          ncyc = 0, hs_n = -1;
    logic        cur_we;
    logic [24:0] cur_addr;
    logic [15:0] cur_data;
    logic [1:0]  cur_mask;

    task automatic do_req(input bit we, input logic [24:0] addr, input logic [15:0] dat, input logic [1:0] m);
        logic [15:0] o;
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = addr; req_wdata = dat; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        hs_n = ncyc + 1;
        cur_we = we; cur_addr = addr; cur_data = dat; cur_mask = m;
        o = exp_mem.exists(addr) ? exp_mem[addr] : 16'h0000;
        if (we) exp_mem[addr] = {m[1] ? o[15:8] : dat[15:8], m[0] ? o[7:0] : dat[7:0]};
        else    expq.push_back(o);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // command monitor, samples on the falling edge
    localparam logic [3:0] INIT_SEQ [4] = '{C_PRE, C_REF, C_REF, C_MRS};
    localparam int         INIT_GAP [4] = '{0, TRP, TRC, TRC};
    int init_idx = 0, last_cmd_n = 0, last_act = -1000, last_ref = -1000;
    int last_rd = -1000, post_ref_n = -1, ref_cnt = 0;
    bit ref_w_wait = 0;

    always @(negedge clk) begin
        ncyc = ncyc + 1;
        if (rst_n) begin
            if (init_idx < 4) begin
                if (cmd != C_NOP) begin
                    chk(cmd == INIT_SEQ[init_idx], "R2/R3 start-up command order", cmd, INIT_SEQ[init_idx]);
                    if (init_idx > 0)
                        chk(ncyc - last_cmd_n == INIT_GAP[init_idx], "R2 start-up spacing",
                            ncyc - last_cmd_n, INIT_GAP[init_idx]);
                    if (cmd == C_PRE) chk(sd_a[10] == 1'b1, "R2 precharge-all A10", sd_a[10], 1);
                    if (cmd == C_MRS) chk(sd_a == 13'h030 && sd_ba == 2'b00, "R2 mode word", sd_a, 13'h030);
                    if (cmd == C_REF) last_ref = ncyc;
                    last_cmd_n = ncyc;
                    init_idx++;
                end
            end else begin
                case (cmd)
                    C_ACT: begin
                        chk(ncyc == hs_n, "R4 activate follows handshake", ncyc, hs_n);
                        chk({sd_ba, sd_a} == cur_addr[24:10], "R4 bank/row", {sd_ba, sd_a}, cur_addr[24:10]);
                        chk(ncyc - last_act >= TGAP, "R8 activate spacing", ncyc - last_act, TGAP);
                        chk(ncyc - last_ref >= TRC, "R9 refresh to activate", ncyc - last_ref, TRC);
                        chk(ncyc - last_cmd_n >= 2, "R2 mode set quiet time", ncyc - last_cmd_n, 2);
                        if (ref_w_wait)
                            chk(ncyc - last_ref == TRC, "R10 waiting request after refresh", ncyc - last_ref, TRC);
                        ref_w_wait = 0;
                        last_act = ncyc;
                    end
                    C_RD, C_WR: begin
                        chk(ncyc - last_act == TRCD, "R5 column command delay", ncyc - last_act, TRCD);
                        chk(sd_a[12:10] == 3'b001 && sd_a[9:0] == cur_addr[9:0] && sd_ba == cur_addr[24:23],
                            "R5 column address", {sd_ba, sd_a}, {cur_addr[24:23], 3'b001, cur_addr[9:0]});
                        chk((cmd == C_WR) == cur_we, "R3 read/write encoding", cmd, cur_we ? C_WR : C_RD);
                        if (cmd == C_WR)
                            chk(sd_dq_oe && sd_dq_out == cur_data && sd_dqm == cur_mask, "R6 write data/mask",
                                {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, cur_mask, cur_data});
                        else begin
                            chk(!sd_dq_oe && sd_dqm == 2'b00, "R6 read cycle bus", {sd_dq_oe, sd_dqm}, 0);
                            last_rd = ncyc;
                        end
                    end
                    C_REF: begin
                        chk(ncyc - last_act >= TGAP, "R9 refresh with rows closed", ncyc - last_act, TGAP);
                        if (post_ref_n >= 0)
                            chk(ncyc - post_ref_n <= RINT + TGAP + 1 && ncyc - post_ref_n >= RINT - TGAP - 1,
                                "R10 refresh interval", ncyc - post_ref_n, RINT);
                        ref_w_wait = req_valid;
                        post_ref_n = ncyc;
                        last_ref   = ncyc;
                        ref_cnt++;
                    end
                    C_NOP: begin
                        if (sd_dq_oe || sd_dqm != 2'b00)
                            chk(0, "R6 bus idle between writes", {sd_dq_oe, sd_dqm}, 0);
                    end
                    default: chk(0, "R3 unexpected command", cmd, C_NOP);
                endcase
            end
            if (rd_valid) begin
                logic [15:0] e;
                e = (expq.size() > 0) ? expq.pop_front() : 16'hFFFF;
                chk(ncyc - last_rd == RDLAT, "R7 read data latency", ncyc - last_rd, RDLAT);
                chk(rd_data == e, "R7 read data", rd_data, e);
            end
        end
    end

    logic [24:0] pool [16];

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!sd_cke && cmd == C_NOP && !req_ready && !rd_valid && !sd_dq_oe, "R1 reset outputs",
            {sd_cke, cmd, req_ready, rd_valid, sd_dq_oe}, {1'b0, C_NOP, 3'b000});
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners: R4 R5 R6 R7
        do_req(1, {2'b00, 13'h0000, 10'h000}, 16'h1234, 2'b00);
        do_req(1, {2'b11, 13'h1FFF, 10'h3FF}, 16'hA5C3, 2'b00);
        do_req(0, {2'b00, 13'h0000, 10'h000}, 16'h0, 2'b00);
        do_req(0, {2'b11, 13'h1FFF, 10'h3FF}, 16'h0, 2'b00);
        do_req(1, {2'b11, 13'h1FFF, 10'h3FF}, 16'hFFFF, 2'b01);
        do_req(0, {2'b11, 13'h1FFF, 10'h3FF}, 16'h0, 2'b00);
        do_req(1, {2'b01, 13'h0AAA, 10'h155}, 16'h7788, 2'b10);
        do_req(0, {2'b01, 13'h0AAA, 10'h155}, 16'h0, 2'b00);
        do_req(1, {2'b10, 13'h1555, 10'h2AA}, 16'h9999, 2'b11);
        do_req(0, {2'b10, 13'h1555, 10'h2AA}, 16'h0, 2'b00);
        // random traffic over a small address pool (R8 R10 under load)
        for (int i = 0; i < 16; i++) pool[i] = 25'($urandom);
        for (int i = 0; i < 16; i++) do_req(1, pool[i], 16'($urandom), 2'b00);
        for (int i = 0; i < 500; i++) begin
            do_req(1'($urandom), pool[$urandom % 16], 16'($urandom), 2'($urandom));
            if ($urandom % 8 == 0) idle($urandom % 4);
        end
        // quiet stretch: refresh keeps running while idle (R9)
        idle(2 * RINT + 50);
        do_req(0, pool[3], 16'h0, 2'b00);
        idle(20);
        chk(expq.size() == 0, "R7 every read returned", expq.size(), 0);
        chk(ref_cnt >= 6, "R9 periodic refresh count", ref_cnt, 6);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule